// File: doc/BRIEF.md
# SEC-DED Memory Word Protection

This block sits between a memory and its users and protects every stored word with a single-error-correcting, double-error-detecting Hamming code. The write path takes a 64-bit data word and returns a 72-bit code word: seven Hamming check bits at the power-of-two positions and one whole-word parity bit in the top position. The read path takes a 72-bit word fetched from memory. It forms the syndrome and the whole-word parity, repairs any single flipped bit, and returns the data with two status flags.

Each path is a valid/ready stream with exactly one register stage. A beat moves across an interface in a cycle where valid and ready are both high at the rising clock edge. A stage accepts a new beat whenever it is empty or its output is being taken in the same cycle. While its output is stalled, the stage holds the output beat unchanged and lowers its input ready. A sender must keep valid and its payload steady until the beat is taken.

Top module: `secded_word_guard`

## Requirements
- R1: Code-word position k (counted from 1) is held in bit k-1. Check bits occupy positions 1, 2, 4, 8, 16, 32 and 64, which are bits 0, 1, 3, 7, 15, 31 and 63. Data bit 0 upward fill the remaining positions 3, 5, 6, 7, 9, ... up to 71 in ascending order. Bit 71 (position 72) is the whole-word parity bit.
- R2: Each check bit at position 2^i gives even parity over every position from 1 to 71 whose binary index has bit i set.
- R3: The whole-word parity bit makes all 72 bits of an emitted code word have even parity.
- R4: A received word with a zero syndrome and even overall parity returns its data unchanged, with both flags low.
- R5: A single flipped bit anywhere in positions 1 to 71 is repaired: the data returned is the original, and the corrected flag is high.
- R6: A flip of the whole-word parity bit alone (zero syndrome, odd parity) returns the data unchanged, with the corrected flag high.
- R7: A nonzero syndrome with even overall parity raises the uncorrectable flag. The data field of the received word is then returned without any repair, and the corrected flag stays low.
- R8: A syndrome above 71 with odd overall parity is treated as uncorrectable: the uncorrectable flag is raised and the data is returned without repair.
- R9: The corrected flag and the uncorrectable flag are never high together.
- R10: Each path has one register stage. A beat accepted at one edge is presented at the output after that edge. Input ready equals (output not valid) or (output ready). While the output is valid and not ready, the output beat stays valid and unchanged.
- R11: While reset is asserted, and directly after it is released, both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_in_valid | input | 1 | Data word offered to the write path |
| wr_in_ready | output | 1 | Write path can take a word |
| wr_in_data | input | 64 | Data word to protect |
| wr_out_valid | output | 1 | Code word available |
| wr_out_ready | input | 1 | Consumer takes the code word |
| wr_out_code | output | 72 | Protected code word |
| rd_in_valid | input | 1 | Fetched code word offered to the read path |
| rd_in_ready | output | 1 | Read path can take a word |
| rd_in_code | input | 72 | Code word fetched from memory |
| rd_out_valid | output | 1 | Checked data available |
| rd_out_ready | input | 1 | Consumer takes the checked data |
| rd_out_data | output | 64 | Repaired (or raw, if uncorrectable) data |
| rd_out_fixed | output | 1 | A single error was found and repaired |
| rd_out_bad | output | 1 | An uncorrectable error was found |

## Verification
The bench builds the block with its default 64-bit data width. This gives a 72-bit word with seven check bits whose syndrome can take values from 72 to 127 that match no position. A three-bit flip of positions 1, 8 and 64 produces syndrome 73, which reaches the out-of-range rule. The same width puts the last data bit at position 71 and the first check bit beyond the lower ones at 64, so single flips at the top data position, at a high check bit and at the overall bit are all covered. The stall sequence fills the write stage while its output is blocked, which shows the held beat and the lowered input ready.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Smallest check-bit count p with 2^p >= p + d + 1.
  function automatic int check_bits(input int d);
    int p;
    p = 0;
    while ((1 << p) < p + d + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/secded_reg_stage.sv
module secded_reg_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R10: a stalled beat is held, neither dropped nor altered
  assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
  // R11: output is idle right after reset release
  assert_idle_after_reset_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);

endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CHK_W  = check_bits(DATA_W),
  localparam int HAM_N  = DATA_W + CHK_W,
  localparam int CODE_W = HAM_N + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    logic [CODE_W-1:0] w;
    logic              par;
    int                k;
    w = '0;
    k = 0;
    // Scatter data into the non-power-of-two positions (R1)
    for (int pos = 1; pos <= HAM_N; pos++) begin
      if (!is_pow2(pos)) begin
        w[pos-1] = data[k];
        k++;
      end
    end
    // Check bit i evens out its group (R2)
    for (int i = 0; i < CHK_W; i++) begin
      par = 1'b0;
      for (int pos = 1; pos <= HAM_N; pos++)
        if ((pos & (1 << i)) != 0) par ^= w[pos-1];
      w[(1 << i) - 1] = par;
    end
    // Whole-word parity at the top position (R3)
    w[CODE_W-1] = ^w[HAM_N-1:0];
    code = w;
  end

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CHK_W  = check_bits(DATA_W),
  localparam int HAM_N  = DATA_W + CHK_W,
  localparam int CODE_W = HAM_N + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic              fixed,
  output logic              bad
);

  logic [CHK_W-1:0]  syn;
  logic              odd;
  logic              syn_nz;
  logic              in_range;
  logic              single;
  logic [CODE_W-1:0] repaired;

  always_comb begin
    for (int i = 0; i < CHK_W; i++) begin
      syn[i] = 1'b0;
      for (int pos = 1; pos <= HAM_N; pos++)
        if ((pos & (1 << i)) != 0) syn[i] ^= code[pos-1];
    end
  end

  assign odd      = ^code;
  assign syn_nz   = |syn;
  assign in_range = (int'(syn) <= HAM_N);
  assign single   = syn_nz && odd && in_range;
  assign fixed    = single || (!syn_nz && odd);
  assign bad      = syn_nz && (!odd || !in_range);

  always_comb begin
    int k;
    repaired = code;
    for (int pos = 1; pos <= HAM_N; pos++)
      if (single && (int'(syn) == pos)) repaired[pos-1] = ~code[pos-1];
    k = 0;
    data = '0;
    for (int pos = 1; pos <= HAM_N; pos++) begin
      if (!is_pow2(pos)) begin
        data[k] = repaired[pos-1];
        k++;
      end
    end
  end

endmodule

// File: rtl/secded_word_guard.sv
module secded_word_guard
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CHK_W  = check_bits(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_in_valid,
  output logic              wr_in_ready,
  input  logic [DATA_W-1:0] wr_in_data,
  output logic              wr_out_valid,
  input  logic              wr_out_ready,
  output logic [CODE_W-1:0] wr_out_code,
  input  logic              rd_in_valid,
  output logic              rd_in_ready,
  input  logic [CODE_W-1:0] rd_in_code,
  output logic              rd_out_valid,
  input  logic              rd_out_ready,
  output logic [DATA_W-1:0] rd_out_data,
  output logic              rd_out_fixed,
  output logic              rd_out_bad
);

  localparam int RD_W = DATA_W + 2;

  logic [CODE_W-1:0] enc_code;
  logic [DATA_W-1:0] dec_data;
  logic              dec_fixed;
  logic              dec_bad;
  logic [RD_W-1:0]   rd_payload;

  secded_encoder #(.DATA_W(DATA_W)) u_enc (
    .data (wr_in_data),
    .code (enc_code)
  );

  secded_reg_stage #(.W(CODE_W)) u_wr_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_in_valid),
    .in_ready  (wr_in_ready),
    .in_data   (enc_code),
    .out_valid (wr_out_valid),
    .out_ready (wr_out_ready),
    .out_data  (wr_out_code)
  );

  secded_decoder #(.DATA_W(DATA_W)) u_dec (
    .code  (rd_in_code),
    .data  (dec_data),
    .fixed (dec_fixed),
    .bad   (dec_bad)
  );

  secded_reg_stage #(.W(RD_W)) u_rd_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rd_in_valid),
    .in_ready  (rd_in_ready),
    .in_data   ({dec_bad, dec_fixed, dec_data}),
    .out_valid (rd_out_valid),
    .out_ready (rd_out_ready),
    .out_data  (rd_payload)
  );

  assign rd_out_data  = rd_payload[DATA_W-1:0];
  assign rd_out_fixed = rd_payload[DATA_W];
  assign rd_out_bad   = rd_payload[DATA_W+1];

  // R3: every emitted code word carries even parity
  assert_code_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_valid |-> (^wr_out_code == 1'b0));
  // R9: the two status flags exclude each other
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid |-> !(rd_out_fixed && rd_out_bad));

endmodule

// File: tb/secded_word_guard_tb.sv
module secded_word_guard_tb_top;

  localparam int DW = 64;
  localparam int CW = 72;
  localparam int HN = 71;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_in_valid = 1'b0;
  logic          wr_in_ready;
  logic [DW-1:0] wr_in_data = '0;
  logic          wr_out_valid;
  logic          wr_out_ready = 1'b1;
  logic [CW-1:0] wr_out_code;
  logic          rd_in_valid = 1'b0;
  logic          rd_in_ready;
  logic [CW-1:0] rd_in_code = '0;
  logic          rd_out_valid;
  logic          rd_out_ready = 1'b1;
  logic [DW-1:0] rd_out_data;
  logic          rd_out_fixed;
  logic          rd_out_bad;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  secded_word_guard dut_i (.*);

  // {data[89:26], flip_a[25:18], flip_b[17:10], flip_c[9:2], class[1:0]}
  // class: 0 clean, 1 corrected, 2 uncorrectable; flip 0 = none
  localparam logic [89:0] VEC [10] = '{
    {64'h0000_0000_0000_0000, 8'd0,  8'd0,  8'd0,  2'd0},
    {64'hFFFF_FFFF_FFFF_FFFF, 8'd0,  8'd0,  8'd0,  2'd0},
    {64'h0123_4567_89AB_CDEF, 8'd3,  8'd0,  8'd0,  2'd1},
    {64'hDEAD_BEEF_CAFE_F00D, 8'd64, 8'd0,  8'd0,  2'd1},
    {64'hA5A5_A5A5_A5A5_A5A5, 8'd71, 8'd0,  8'd0,  2'd1},
    {64'h5A5A_5A5A_5A5A_5A5A, 8'd72, 8'd0,  8'd0,  2'd1},
    {64'h0000_0000_0000_0001, 8'd3,  8'd5,  8'd0,  2'd2},
    {64'h8000_0000_0000_0000, 8'd72, 8'd10, 8'd0,  2'd2},
    {64'h0000_0000_0000_CAFE, 8'd1,  8'd8,  8'd64, 2'd2},
    {64'h0F0F_0F0F_0F0F_0F0F, 8'd2,  8'd0,  8'd0,  2'd1}
  };

  function automatic bit pow2(int v);
    return (v & (v - 1)) == 0;
  endfunction

  function automatic logic [CW-1:0] model_encode(logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= HN; p++)
      if (!pow2(p)) begin c[p-1] = d[j]; j++; end
    for (int b = 1; b <= 64; b = b * 2) begin
      logic s;
      s = 1'b0;
      for (int p = 1; p <= HN; p++) if ((p & b) != 0) s ^= c[p-1];
      c[b-1] = s;
    end
    c[CW-1] = ^c[HN-1:0];
    return c;
  endfunction

  function automatic logic [DW-1:0] model_extract(logic [CW-1:0] c);
    logic [DW-1:0] d;
    int j;
    j = 0;
    d = '0;
    for (int p = 1; p <= HN; p++)
      if (!pow2(p)) begin d[j] = c[p-1]; j++; end
    return d;
  endfunction

  function automatic int model_syndrome(logic [CW-1:0] c);
    int s;
    s = 0;
    for (int p = 1; p <= HN; p++) if (c[p-1]) s ^= p;
    return s;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_beat(input logic [DW-1:0] d, output logic [CW-1:0] c);
    @(negedge clk);
    wr_in_valid = 1'b1;
    wr_in_data  = d;
    @(negedge clk);
    wr_in_valid = 1'b0;
    chk("R10 write latency", {127'd0, wr_out_valid}, 128'd1);
    c = wr_out_code;
  endtask

  task automatic read_beat(input logic [CW-1:0] c);
    @(negedge clk);
    rd_in_valid = 1'b1;
    rd_in_code  = c;
    @(negedge clk);
    rd_in_valid = 1'b0;
    chk("R10 read latency", {127'd0, rd_out_valid}, 128'd1);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] code, bad_word, code_a, code_b;
    logic [DW-1:0] d, exp_d;
    int            cls, fa, fb, fc;
    string         tag;

    // Reset state (R11)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 wr valid in reset", {127'd0, wr_out_valid}, 128'd0);
    chk("R11 rd valid in reset", {127'd0, rd_out_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 wr valid after reset", {127'd0, wr_out_valid}, 128'd0);
    chk("R11 rd valid after reset", {127'd0, rd_out_valid}, 128'd0);
    chk("R10 ready when empty", {126'd0, wr_in_ready, rd_in_ready}, 128'd3);

    // Vector table walk
    for (int i = 0; i < 10; i++) begin
      d   = VEC[i][89:26];
      fa  = int'(VEC[i][25:18]);
      fb  = int'(VEC[i][17:10]);
      fc  = int'(VEC[i][9:2]);
      cls = int'(VEC[i][1:0]);
      write_beat(d, code);
      chk("R1 code layout", {56'd0, code}, {56'd0, model_encode(d)});
      chk("R2 check groups even", 128'(model_syndrome(code)), 128'd0);
      chk("R3 whole word even", {127'd0, ^code}, 128'd0);

      bad_word = code;
      if (fa != 0) bad_word[fa-1] = ~bad_word[fa-1];
      if (fb != 0) bad_word[fb-1] = ~bad_word[fb-1];
      if (fc != 0) bad_word[fc-1] = ~bad_word[fc-1];
      read_beat(bad_word);

      if (cls == 0)       tag = "R4";
      else if (cls == 1)  tag = (fa == 72) ? "R6" : "R5";
      else                tag = (fc != 0) ? "R8" : "R7";
      exp_d = (cls == 2) ? model_extract(bad_word) : d;
      chk({tag, " data"}, {64'd0, rd_out_data}, {64'd0, exp_d});
      chk({tag, " fixed flag"}, {127'd0, rd_out_fixed}, {127'd0, cls == 1});
      chk({tag, " bad flag"}, {127'd0, rd_out_bad}, {127'd0, cls == 2});
      chk("R9 flags exclusive", {127'd0, rd_out_fixed & rd_out_bad}, 128'd0);
    end

    // Back-pressure on the write path (R10)
    wr_out_ready = 1'b0;
    @(negedge clk);
    wr_in_valid = 1'b1;
    wr_in_data  = 64'h1111_2222_3333_4444;
    @(negedge clk);
    code_a = wr_out_code;
    chk("R10 stalled first beat", {56'd0, code_a}, {56'd0, model_encode(64'h1111_2222_3333_4444)});
    wr_in_data = 64'h9999_8888_7777_6666;
    chk("R10 ready low while stalled", {127'd0, wr_in_ready}, 128'd0);
    repeat (3) @(negedge clk);
    chk("R10 beat held valid", {127'd0, wr_out_valid}, 128'd1);
    chk("R10 beat held stable", {56'd0, wr_out_code}, {56'd0, code_a});
    chk("R10 ready low after hold", {127'd0, wr_in_ready}, 128'd0);
    wr_out_ready = 1'b1;
    @(negedge clk);
    wr_in_valid = 1'b0;
    code_b = wr_out_code;
    chk("R10 next beat after release", {56'd0, code_b}, {56'd0, model_encode(64'h9999_8888_7777_6666)});
    @(negedge clk);
    chk("R10 drained", {127'd0, wr_out_valid}, 128'd0);

    // Back-pressure on the read path (R10)
    rd_out_ready = 1'b0;
    read_beat(model_encode(64'h0000_FFFF_0000_FFFF));
    chk("R10 read ready low", {127'd0, rd_in_ready}, 128'd0);
    @(negedge clk);
    chk("R10 read data held", {64'd0, rd_out_data}, {64'd0, 64'h0000_FFFF_0000_FFFF});
    rd_out_ready = 1'b1;
    @(negedge clk);
    chk("R10 read drained", {127'd0, rd_out_valid}, 128'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule